// File: doc/BRIEF.md
# Oversampled SPI Word Slave

This block is an SPI slave for mode 0 (clock idles low, data captured on the rising clock edge, data launched on the falling edge). It runs entirely on the system clock. The serial clock, the data input and the select line from the pins are treated as ordinary asynchronous data. Each is resynchronized, and edges of the serial clock are found by comparing successive samples. The block is meant for links where the system clock is at least about four times faster than the serial clock. In exchange for that limit, the whole block is a single clock domain.

Received words go into a one-word holding register and leave on a valid/ready stream. Words to be sent enter on a second valid/ready stream and wait in a one-word register. At each word boundary that register is loaded into the output shift register. Framing depends only on a bit counter. The select line may be tied low permanently. A high level on the select line, rather than an edge, returns the counter to bit zero and discards a partly received word. The word width and the bit order are parameters. The bit order applies to both directions.

Top module: `spi_word_slave`

## Requirements
- R1: After reset, `rx_valid` is 0, `tx_ready` is 1, `miso_pin` is 0, and `rx_overrun` and `tx_underrun` are 0.
- R2: With `LSB_FIRST=0`, the first bit captured on a rising `sclk_pin` edge becomes bit WIDTH-1 of `rx_data`. After WIDTH rising edges, the word appears on `rx_data` with `rx_valid` high.
- R3: With `LSB_FIRST=0`, `miso_pin` shows bit WIDTH-1 of the queued transmit word before the first rising edge of a word. It moves to the next lower bit after each falling edge that follows a captured bit.
- R4: With `LSB_FIRST=1`, the first serial bit in either direction is bit 0, and later bits go toward bit WIDTH-1.
- R5: `rx_valid` stays high and `rx_data` stays unchanged until a cycle with `rx_valid` and `rx_ready` both high. After that cycle the holding register is empty unless a new word completes.
- R6: A word that completes while the receive holding register is full, and is not being taken in that cycle, is discarded. The held word stays unchanged, and `rx_overrun` goes to 1 and stays at 1 until reset.
- R7: If no transmit word has been loaded when the first bit of a word is captured, the slave shifts out all zeros for that word. `tx_underrun` goes to 1 and stays at 1 until reset.
- R8: `tx_ready` is high exactly when the one-word transmit register is empty. An accepted word moves into the output shift register when it is empty between words. That frees the register, so a second word can wait behind one being sent.
- R9: With the select line held low continuously, consecutive words are framed by the bit count alone. Each group of WIDTH rising edges is one word.
- R10: A high level on `ssn_pin` while a word is in progress discards the partial receive word and the partly sent transmit word. The next word after the select line goes low again starts at bit zero.
- R11: Clock edges seen while the synchronized select line is high neither capture nor shift any bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_pin | input | 1 | Serial clock from the master (asynchronous) |
| mosi_pin | input | 1 | Serial data from the master (asynchronous) |
| ssn_pin | input | 1 | Active-low select from the master (asynchronous) |
| miso_pin | output | 1 | Serial data to the master |
| rx_data | output | WIDTH | Received word |
| rx_valid | output | 1 | Receive holding register is full |
| rx_ready | input | 1 | Consumer takes the received word |
| tx_data | input | WIDTH | Word to transmit |
| tx_valid | input | 1 | Producer offers a transmit word |
| tx_ready | output | 1 | Transmit register is empty |
| rx_overrun | output | 1 | Sticky: a received word was dropped |
| tx_underrun | output | 1 | Sticky: zeros were sent for lack of data |

## Verification
The bound checker watches, on every cycle, the stream rules at the parallel side. It checks that a pending receive word holds steady, that the transmit register closes after accepting a word, that both error flags are sticky, and that no word can appear while the select line has been high for several cycles. Bit ordering in both directions, the MISO launch timing against a bit-banged master, overrun and underrun behaviour, back-to-back words with the select line held low, and recovery from an aborted word can only be shown by the bench's serial scenarios. Each scenario compares the words exchanged against values the bench computes itself.

// File: rtl/spi_word_slave.sv
module spi_word_slave #(
  parameter int WIDTH     = 8,
  parameter bit LSB_FIRST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_pin,
  input  logic             mosi_pin,
  input  logic             ssn_pin,
  output logic             miso_pin,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             rx_overrun,
  output logic             tx_underrun
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [1:0] sclk_sync, mosi_sync, ssn_sync;
  logic       sclk_prev;
  logic       sclk_s, mosi_s, ssn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= 2'b00;
      mosi_sync <= 2'b00;
      ssn_sync  <= 2'b11;
      sclk_prev <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[0], sclk_pin};
      mosi_sync <= {mosi_sync[0], mosi_pin};
      ssn_sync  <= {ssn_sync[0], ssn_pin};
      sclk_prev <= sclk_sync[1];
    end
  end

  assign sclk_s = sclk_sync[1];
  assign mosi_s = mosi_sync[1];
  assign ssn_s  = ssn_sync[1];

  logic rise, fall;
  assign rise = sclk_s & ~sclk_prev & ~ssn_s;
  assign fall = ~sclk_s & sclk_prev & ~ssn_s;

  logic [CW-1:0] cnt;
  logic          at_first, at_last, done, abort;
  assign at_first = (cnt == '0);
  assign at_last  = (cnt == LAST);
  assign done     = rise & at_last;
  assign abort    = ssn_s & ~at_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (ssn_s)  cnt <= '0;
    else if (rise)   cnt <= at_last ? '0 : cnt + 1'b1;
  end

  logic [WIDTH-1:0] rx_sh, rx_word, tx_sh, tx_next;
  logic             miso_bit;

  generate
    if (WIDTH == 1) begin : g_one
      assign rx_word  = mosi_s;
      assign tx_next  = tx_sh;
      assign miso_bit = tx_sh[0];
    end else if (LSB_FIRST) begin : g_lsb
      assign rx_word  = {mosi_s, rx_sh[WIDTH-1:1]};
      assign tx_next  = {1'b0, tx_sh[WIDTH-1:1]};
      assign miso_bit = tx_sh[0];
    end else begin : g_msb
      assign rx_word  = {rx_sh[WIDTH-2:0], mosi_s};
      assign tx_next  = {tx_sh[WIDTH-2:0], 1'b0};
      assign miso_bit = tx_sh[WIDTH-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_sh <= '0;
    else if (rise) rx_sh <= rx_word;
  end

  logic rx_pop;
  assign rx_pop = rx_valid & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_overrun <= 1'b0;
    end else begin
      if (done && (!rx_valid || rx_pop)) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_word;
      end else if (rx_pop) begin
        rx_valid <= 1'b0;
      end
      if (done && rx_valid && !rx_pop) rx_overrun <= 1'b1;
    end
  end

  logic             tx_full, armed, tx_push, tx_load, starve;
  logic [WIDTH-1:0] tx_hold;

  assign tx_ready = ~tx_full;
  assign tx_push  = tx_valid & ~tx_full;
  assign starve   = rise & at_first & ~armed;
  assign tx_load  = ~armed & tx_full & at_first & ~rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else if (tx_push) begin
      tx_full <= 1'b1;
      tx_hold <= tx_data;
    end else if (tx_load) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh       <= '0;
      armed       <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      if (starve) tx_underrun <= 1'b1;
      if (done || abort) begin
        tx_sh <= '0;
        armed <= 1'b0;
      end else if (starve) begin
        armed <= 1'b1;
      end else if (tx_load) begin
        tx_sh <= tx_hold;
        armed <= 1'b1;
      end else if (fall && !at_first) begin
        tx_sh <= tx_next;
      end
    end
  end

  assign miso_pin = miso_bit;
endmodule

module spi_word_slave_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ssn_pin,
  input logic [WIDTH-1:0] rx_data,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_overrun,
  input logic             tx_underrun
);
  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_tx_one_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> tx_underrun);

  assert_no_word_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ssn_pin && $past(ssn_pin) && $past(ssn_pin, 2) && $past(ssn_pin, 3))
      |-> !$rose(rx_valid));
endmodule

bind spi_word_slave spi_word_slave_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ssn_pin(ssn_pin), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_overrun(rx_overrun), .tx_underrun(tx_underrun)
);

// File: tb/spi_word_slave_bench.sv
module spi_word_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NVEC = 6;
  localparam logic [23:0] VECS [NVEC] = '{
    24'hA5_3C_81, 24'h00_FF_01, 24'hFF_00_80,
    24'h5A_C3_7E, 24'h01_80_10, 24'h96_69_F0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, ssn = 1'b1;
  logic miso_a, miso_b;
  logic [7:0] rxd_a, rxd_b, txd_a = '0, txd_b = '0;
  logic rxv_a, rxv_b, rxr = 1'b0, txv = 1'b0, txr_a, txr_b;
  logic ovr_a, ovr_b, und_a, und_b;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_word_slave #(.WIDTH(8), .LSB_FIRST(1'b0)) u_spi_word_slave (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .mosi_pin(mosi), .ssn_pin(ssn),
    .miso_pin(miso_a), .rx_data(rxd_a), .rx_valid(rxv_a), .rx_ready(rxr),
    .tx_data(txd_a), .tx_valid(txv), .tx_ready(txr_a),
    .rx_overrun(ovr_a), .tx_underrun(und_a));

  spi_word_slave #(.WIDTH(8), .LSB_FIRST(1'b1)) u_spi_word_slave_lsb (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .mosi_pin(mosi), .ssn_pin(ssn),
    .miso_pin(miso_b), .rx_data(rxd_b), .rx_valid(rxv_b), .rx_ready(rxr),
    .tx_data(txd_b), .tx_valid(txv), .tx_ready(txr_b),
    .rx_overrun(ovr_b), .tx_underrun(und_b));

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); txd_a = a; txd_b = b; txv = 1'b1;
    @(negedge clk); txv = 1'b0;
    tick(3);
  endtask

  task automatic pop();
    @(negedge clk); rxr = 1'b1;
    @(negedge clk); rxr = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] mo, input int nbits,
                      output logic [7:0] ma, output logic [7:0] mb);
    ma = '0; mb = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[7-i];
      tick(HALF);
      ma = {ma[6:0], miso_a};
      mb = {mb[6:0], miso_b};
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
  endtask

  task automatic frame(input logic [7:0] mo, output logic [7:0] ma, output logic [7:0] mb);
    ssn = 1'b0; tick(HALF);
    xfer(mo, 8, ma, mb);
    ssn = 1'b1; tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] ma, mb;
    tick(3);
    check("R1 rx_valid", rxv_a, 0);
    check("R1 tx_ready", txr_a, 1);
    check("R1 miso", miso_a, 0);
    check("R1 flags", {ovr_a, und_a}, 0);
    rst_n = 1'b1; tick(3);

    for (int v = 0; v < NVEC; v++) begin
      push(VECS[v][15:8], VECS[v][7:0]);
      frame(VECS[v][23:16], ma, mb);
      check("R2 rx valid", rxv_a, 1);
      check("R2 rx word msb", rxd_a, VECS[v][23:16]);
      check("R3 miso word msb", ma, VECS[v][15:8]);
      check("R4 rx word lsb", rxd_b, rev8(VECS[v][23:16]));
      check("R4 miso word lsb", mb, rev8(VECS[v][7:0]));
      check("R8 tx consumed", txr_a, 1);
      tick(5);
      check("R5 rx held", {rxv_a, rxd_a}, {1'b1, VECS[v][23:16]});
      pop();
      check("R5 rx emptied", rxv_a, 0);
    end

    // R10: abort mid-word, then a clean word
    push(8'hE7, 8'hE7);
    ssn = 1'b0; tick(HALF);
    xfer(8'hB0, 3, ma, mb);
    ssn = 1'b1; tick(8);
    check("R10 partial dropped", rxv_a, 0);
    push(8'h4D, 8'h4D);
    frame(8'hC6, ma, mb);
    check("R10 rx after abort", rxd_a, 8'hC6);
    check("R10 miso after abort", ma, 8'h4D);
    pop();

    // R9 / R8: select held low, two words back to back, one waiting
    push(8'h12, 8'h12);
    push(8'h34, 8'h34);
    check("R8 second word waits", txr_a, 0);
    ssn = 1'b0; tick(HALF);
    xfer(8'h9C, 8, ma, mb);
    check("R9 word one rx", rxd_a, 8'h9C);
    check("R9 word one miso", ma, 8'h12);
    check("R8 reload frees", txr_a, 1);
    pop();
    xfer(8'h27, 8, ma, mb);
    check("R9 word two rx", rxd_a, 8'h27);
    check("R9 word two miso", ma, 8'h34);
    pop();
    ssn = 1'b1; tick(6);
    check("R7 no underrun yet", und_a, 0);
    check("R6 no overrun yet", ovr_a, 0);

    // R6: overrun
    push(8'h55, 8'h55);
    frame(8'h61, ma, mb);
    push(8'hAA, 8'hAA);
    frame(8'h62, ma, mb);
    check("R6 overrun flag", ovr_a, 1);
    check("R6 held word kept", rxd_a, 8'h61);
    pop();
    check("R6 dropped word absent", rxv_a, 0);

    // R7: underrun
    frame(8'h33, ma, mb);
    check("R7 zeros sent", ma, 8'h00);
    check("R7 underrun flag", und_a, 1);
    check("R7 rx still works", rxd_a, 8'h33);
    pop();

    // R11: clock edges while deselected
    xfer(8'hFF, 8, ma, mb);
    tick(6);
    check("R11 no capture deselected", rxv_a, 0);
    check("R6 overrun sticky", ovr_a, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule